// File: doc/BRIEF.md
# Three-Phase Bridge Fault Supervisor

This block sits beside the commutation logic of a three-phase bridge controller and decides when and how the six gate outputs must be forced off. It watches the three Hall sensor lines, an undervoltage flag for the regulated gate supply, a thermal-shutdown flag, one short-to-ground detect flag per motor phase, a commutation strobe and a latch-clear input. It drives three outputs. `coast_o` asks the gate stage to turn off all six switches. `hs_off_o` asks it to turn off only the three high-side switches. `fault_o` is a registered fault level, high while any fault cause is active.

The Hall code, undervoltage and thermal causes are not stored: they force coast only while the condition is present. A ground short on any phase is different. It sets a sticky latch that disables only the high-side switches and leaves the low side under normal control. The latch is released by the next commutation strobe or by the latch-clear input. The clear path is the way out when the motor has stalled and no further commutation will come. All asynchronous inputs pass through a synchronizer before they are used. The commutation strobe is taken to come from logic on the same clock.

Top module: `mdrv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are low after that edge. The synchronizer stages also clear to zero, so the Hall value seen just after reset is 000.
- R2: A Hall code of 000 or 111 is invalid and drives `coast_o` and `fault_o` high. The six other codes are valid. An input held across clock edge n reaches the outputs at edge n+2.
- R3: A high undervoltage flag drives `coast_o` and `fault_o` high, with the same two-edge latency as R2.
- R4: A high thermal flag drives `coast_o` and `fault_o` high, with the same two-edge latency as R2.
- R5: A high ground-short flag on any of the three phases sets the short latch. The latch drives `hs_off_o` and `fault_o` high, and it does not by itself drive `coast_o`.
- R6: The short latch stays set after every short flag has gone low, until it is cleared as in R7 or R8.
- R7: A high `commut_stb_i` at a clock edge clears the short latch at that same edge, unless a short is being set at that edge.
- R8: A high `latch_clr_i` clears the short latch. It passes through the synchronizer, so it acts two edges after it is sampled, and a short being set at the same edge wins.
- R9: When a synchronized short and a clear (strobe or clear input) fall on the same edge, the latch ends up set.
- R10: Coast follows its causes without memory: once the Hall code is valid and the undervoltage and thermal flags are low, `coast_o` drops two edges later.
- R11: `fault_o` is high exactly when `coast_o` or `hs_off_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hall_i | input | 3 | Raw Hall sensor lines |
| uv_i | input | 1 | Gate-supply undervoltage flag |
| ot_i | input | 1 | Thermal-shutdown flag |
| gnd_short_i | input | 3 | Per-phase short-to-ground detect flags |
| commut_stb_i | input | 1 | One-cycle commutation strobe, same clock domain |
| latch_clr_i | input | 1 | Clear request for the short latch |
| fault_o | output | 1 | Registered fault level, high on any fault |
| coast_o | output | 1 | Request to turn off all six switches |
| hs_off_o | output | 1 | Request to turn off the high-side switches only |

## Verification
The bench aims at the edges of the short latch. It drives a strobe while a short is still present, to catch a design that lets the clear win and re-enables the high side over a live short. It also drops the short flag before any strobe, which exposes a latch that merely follows its input. It walks both invalid Hall codes and the release of each coast cause, so a design that latches coast, or that treats only one of 000 and 111 as illegal, gives a wrong output. The first cycles after reset, where the cleared synchronizer presents Hall code 000, are also checked, and so is the two-edge delay of the clear input. A wrong stage count would show up as an off-by-one mismatch.

// File: rtl/mfs_pkg.sv
// Package: shared widths and the bundle of inputs that cross the synchronizer.
// Assumes one Hall line per phase and a three-phase bridge.
package mfs_pkg;
    localparam int PHASES = 3;
    localparam int HALL_W = PHASES;

    // Inputs that pass through the synchronizer, kept together so one
    // instance handles them all.
    typedef struct packed {
        logic [HALL_W-1:0] hall;
        logic              uv;
        logic              ot;
        logic [PHASES-1:0] gshort;
        logic              clr;
    } mfs_in_t;

    localparam int IN_W = $bits(mfs_in_t);
endpackage

// File: rtl/mfs_sync.sv
// Module: multi-stage synchronizer for a bus of independent level signals.
// Assumes each bit is a slow level, so no bit-to-bit coherence is needed.
// All stages clear to zero on the synchronous active-low reset.
module mfs_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: shift toward the output.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mfs_hall_check.sv
// Module: flags a Hall code that cannot occur with 120-degree sensor spacing.
// All-zero and all-one codes are illegal; every other code is legal.
// Purely combinational; the caller registers the result.
module mfs_hall_check #(
    parameter int W = 3
) (
    input  logic [W-1:0] hall_i,
    output logic         bad_o
);
    // Decode the two illegal patterns.
    always_comb begin
        bad_o = (hall_i == {W{1'b0}}) || (hall_i == {W{1'b1}});
    end
endmodule

// File: rtl/mfs_short_latch.sv
// Module: sticky ground-short latch with set-over-clear priority.
// Assumes set_i and clr_i are synchronous to clk. The next state is
// exported so the caller can register a coherent fault level.
module mfs_short_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic nxt_o
);
    // Next-state selection: set wins, then clear, else hold.
    always_comb begin
        if (set_i)      nxt_o = 1'b1;
        else if (clr_i) nxt_o = 1'b0;
        else            nxt_o = q_o;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= nxt_o;
    end

    // R5 R9
    always @(posedge clk)
        set_wins_chk: assert property (disable iff (!rst_n) set_i |=> q_o);

    // R7 R8
    always @(posedge clk)
        clr_takes_chk: assert property (disable iff (!rst_n) (clr_i && !set_i) |=> !q_o);

    // R6
    always @(posedge clk)
        hold_chk: assert property (disable iff (!rst_n) (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/mdrv_fault_supervisor.sv
// Module: fault supervisor for a three-phase bridge controller.
// It classifies the fault causes into a full coast (illegal Hall code,
// undervoltage, thermal) or a high-side-only disable (ground short, latched).
// Assumes commut_stb_i comes from logic on the same clock; every other
// input is asynchronous and is synchronized here.
module mdrv_fault_supervisor
    import mfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_W-1:0] hall_i,
    input  logic              uv_i,
    input  logic              ot_i,
    input  logic [PHASES-1:0] gnd_short_i,
    input  logic              commut_stb_i,
    input  logic              latch_clr_i,
    output logic              fault_o,
    output logic              coast_o,
    output logic              hs_off_o
);
    mfs_in_t raw_in;
    mfs_in_t syn_in;
    logic    hall_bad;
    logic    coast_nxt;
    logic    short_set;
    logic    short_clr;
    logic    short_nxt;

    // Bundle the asynchronous inputs.
    always_comb begin
        raw_in.hall   = hall_i;
        raw_in.uv     = uv_i;
        raw_in.ot     = ot_i;
        raw_in.gshort = gnd_short_i;
        raw_in.clr    = latch_clr_i;
    end

    mfs_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    mfs_hall_check #(
        .W (HALL_W)
    ) u_hall (
        .hall_i (syn_in.hall),
        .bad_o  (hall_bad)
    );

    // Classify the non-latched causes and the latch controls.
    always_comb begin
        coast_nxt = hall_bad | syn_in.uv | syn_in.ot;
        short_set = |syn_in.gshort;
        short_clr = commut_stb_i | syn_in.clr;
    end

    mfs_short_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (short_set),
        .clr_i (short_clr),
        .q_o   (hs_off_o),
        .nxt_o (short_nxt)
    );

    // Output registers: coast request and glitch-free fault level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coast_o <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            coast_o <= coast_nxt;
            fault_o <= coast_nxt | short_nxt;
        end
    end

    // R11
    always @(posedge clk)
        coast_flags_chk: assert property (disable iff (!rst_n) coast_o |-> fault_o);

    // R11
    always @(posedge clk)
        hs_flags_chk: assert property (disable iff (!rst_n) hs_off_o |-> fault_o);

    // R11
    always @(posedge clk)
        no_stray_fault_chk: assert property (disable iff (!rst_n) fault_o |-> (coast_o || hs_off_o));
endmodule

// File: tb/mdrv_fault_supervisor_tb.sv
// Bench: behavioural reference model fed from a delay queue, compared on every falling edge.
module mdrv_fault_supervisor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic       uv = 1'b0;
    logic       ot = 1'b0;
    logic [2:0] gsh = 3'b000;
    logic       stb = 1'b0;
    logic       lclr = 1'b0;
    logic       fault, coast, hs_off;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string tag = "R1";

    // Reference state
    logic [8:0] dq[$];
    logic       m_coast = 1'b0;
    logic       m_fault = 1'b0;
    logic       m_latch = 1'b0;

    always #2.5 clk = ~clk;

    mdrv_fault_supervisor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hall_i       (hall),
        .uv_i         (uv),
        .ot_i         (ot),
        .gnd_short_i  (gsh),
        .commut_stb_i (stb),
        .latch_clr_i  (lclr),
        .fault_o      (fault),
        .coast_o      (coast),
        .hs_off_o     (hs_off)
    );

    // Model: the inputs seen two edges ago drive the decisions; the strobe acts at once.
    always @(posedge clk) begin
        logic [8:0] old;
        logic       bad, cst, set, clr;
        cycles++;
        if (!rst_n) begin
            dq = {};
            dq.push_back(9'd0);
            dq.push_back(9'd0);
            m_coast = 1'b0;
            m_fault = 1'b0;
            m_latch = 1'b0;
        end else begin
            dq.push_back({hall, uv, ot, gsh, lclr});
            old = dq.pop_front();
            bad = (old[8:6] == 3'b000) || (old[8:6] == 3'b111);
            cst = bad || old[5] || old[4];
            set = |old[3:1];
            clr = stb || old[0];
            if (set)      m_latch = 1'b1;
            else if (clr) m_latch = 1'b0;
            m_coast = cst;
            m_fault = cst || m_latch;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        n_checks++;
        if ({fault, coast, hs_off} !== {m_fault, m_coast, m_latch}) begin
            n_fail++;
            $display("FAIL %s cycle %0d: fault/coast/hs_off actual %b%b%b expected %b%b%b",
                     tag, cycles, fault, coast, hs_off, m_fault, m_coast, m_latch);
        end
        n_checks++;
        if (rst_n && (fault !== (coast | hs_off))) begin
            n_fail++;
            $display("FAIL R11 cycle %0d: fault actual %b expected %b",
                     cycles, fault, coast | hs_off);
        end
    end

    // Watchdog
    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stb();
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
    endtask

    initial begin
        tag = "R1";
        step(4);
        rst_n = 1'b1;
        step(4);
        // normal rotation, valid codes with strobes
        tag = "R7";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            case (i)
                0: hall = 3'b001; 1: hall = 3'b011; 2: hall = 3'b010;
                3: hall = 3'b110; 4: hall = 3'b100; default: hall = 3'b101;
            endcase
            stb = 1'b1;
            @(negedge clk); stb = 1'b0;
            step(2);
        end
        tag = "R2"; hall = 3'b000; step(4);
        tag = "R10"; hall = 3'b011; step(4);
        tag = "R2"; hall = 3'b111; step(4);
        tag = "R10"; hall = 3'b110; step(4);
        tag = "R3"; uv = 1'b1; step(1); uv = 1'b0; step(4);
        uv = 1'b1; step(5);
        tag = "R10"; uv = 1'b0; step(4);
        tag = "R4"; ot = 1'b1; step(5);
        tag = "R10"; ot = 1'b0; step(4);
        // ground short on each phase in turn
        for (int p = 0; p < 3; p++) begin
            tag = "R5"; gsh = 3'b001 << p; step(3);
            tag = "R6"; gsh = 3'b000; step(6);
            tag = "R7"; pulse_stb(); step(3);
        end
        // strobe while short still present
        tag = "R9"; gsh = 3'b100; step(3);
        pulse_stb(); step(2);
        lclr = 1'b1; step(2); lclr = 1'b0;
        gsh = 3'b000; step(4);
        tag = "R8"; lclr = 1'b1; step(1); lclr = 1'b0; step(5);
        // short together with a coast cause
        tag = "R11"; gsh = 3'b010; uv = 1'b1; step(4);
        gsh = 3'b000; step(2); uv = 1'b0; step(4);
        pulse_stb(); step(3);
        // reset clears a held latch
        tag = "R1"; gsh = 3'b001; step(3); gsh = 3'b000;
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(5);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule